// File: doc/BRIEF.md
# One-Shot Arm Trigger with All-Ones Detect

This block produces a short trigger pulse that is armed only by reset. A synchronous reset sets an arming flag, so the trigger output goes high right after the reset edge. On the first clock edge after reset is released, the block looks at a 128-bit input word. If every bit of that word is one, the pulse is stretched by one more cycle through a second holding flag. If not, the pulse ends at that edge.

Once both flags are clear, the trigger stays low whatever the input word carries. Only a new reset raises it again. A separate output shows, combinationally, whether the current input word is all ones. The input word is sampled on every clock edge and has no handshake. Neither side can apply back-pressure: the source presents a word on each cycle, and the block neither stalls nor queues it.

Top module: `pulse_arm_trigger`

## Requirements
- R1: `match_out` is 1 in the same cycle exactly when all 128 bits of `word_in` are 1. A single zero bit in any position, lowest, highest or middle, makes it 0.
- R2: `rst` is synchronous and active high. After any rising edge at which `rst` is 1, `trig_out` is 1, whatever the value of `word_in`.
- R3: If `match_out` is 1 at the first edge after `rst` is released, `trig_out` stays 1 for exactly one further cycle. The pulse after release then lasts two cycles.
- R4: If `match_out` is 0 at the first edge after `rst` is released, `trig_out` goes to 0 after that edge.
- R5: The extension cycle cannot itself be extended. A match at the edge that ends it still brings `trig_out` to 0.
- R6: Once `trig_out` is 0, it stays 0 under any `word_in`, including all ones, until an edge with `rst` at 1. It never rises except after such an edge.
- R7: Reset takes priority over the extension. An edge with `rst` at 1 during the extension cycle re-arms the block, and the next release evaluates the match again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset; it is also the only arming source |
| word_in | input | 128 | Word compared against all ones |
| trig_out | output | 1 | Trigger pulse, the OR of the arming flag and the holding flag |
| match_out | output | 1 | High while `word_in` is all ones |

## Verification
The checker assumes that `rst` is high at the very first clock edge. Its temporal properties stay disabled until such an edge has been seen, because before it the flags hold no defined value. It also assumes that `word_in` and `rst` change only away from the rising edge. The bench asserts reset from time zero and holds it for several cycles before every scenario. It changes the inputs only one time unit after a rising edge, so every property sees a clean sample. The bench drives all-ones words deliberately at the sensitive edges: during reset, at release, at the end of the extension, and long after the pulse.

// File: rtl/trig_pkg.sv
package trig_pkg;
  localparam int unsigned DEF_WORD_W  = 128;
  localparam int unsigned DEF_CHUNK_W = 16;

  typedef struct packed {
    logic armed;  // set only by reset
    logic held;   // one-cycle extension after a match
  } trig_flags_t;

  localparam trig_flags_t FLAGS_ARMED = '{armed: 1'b1, held: 1'b0};
  localparam trig_flags_t FLAGS_HELD  = '{armed: 1'b0, held: 1'b1};
  localparam trig_flags_t FLAGS_IDLE  = '{armed: 1'b0, held: 1'b0};
endpackage

// File: rtl/ones_detect.sv
module ones_detect #(
  parameter int unsigned WORD_W  = trig_pkg::DEF_WORD_W,
  parameter int unsigned CHUNK_W = trig_pkg::DEF_CHUNK_W
) (
  input  logic [WORD_W-1:0] word_i,
  output logic              all_ones_o
);
  localparam int unsigned NUM_CHUNKS = (WORD_W + CHUNK_W - 1) / CHUNK_W;
  localparam int unsigned PAD_W      = NUM_CHUNKS * CHUNK_W;

  logic [PAD_W-1:0]      padded;
  logic [NUM_CHUNKS-1:0] chunk_full;

  // unused top bits of the last chunk are padded with ones
  generate
    if (PAD_W == WORD_W) begin : g_nopad
      assign padded = word_i;
    end else begin : g_pad
      assign padded = {{(PAD_W-WORD_W){1'b1}}, word_i};
    end
  endgenerate

  generate
    for (genvar c = 0; c < NUM_CHUNKS; c++) begin : g_chunk
      assign chunk_full[c] = &padded[c*CHUNK_W +: CHUNK_W];
    end
  endgenerate

  assign all_ones_o = &chunk_full;
endmodule

// File: rtl/flag_ctrl.sv
module flag_ctrl
  import trig_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        match_i,
  output trig_flags_t flags_o
);
  trig_flags_t flags_q, flags_d;

  always_comb begin
    if (flags_q.armed && match_i) begin
      flags_d = FLAGS_HELD;
    end else begin
      flags_d = FLAGS_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= FLAGS_ARMED;
    end else begin
      flags_q <= flags_d;
    end
  end

  assign flags_o = flags_q;
endmodule

// File: rtl/pulse_arm_trigger.sv
module pulse_arm_trigger
  import trig_pkg::*;
#(
  parameter int unsigned WORD_W  = DEF_WORD_W,
  parameter int unsigned CHUNK_W = DEF_CHUNK_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] word_in,
  output logic              trig_out,
  output logic              match_out
);
  logic        hit;
  trig_flags_t flags;
  logic        armed_q;
  logic        held_q;

  ones_detect #(.WORD_W(WORD_W), .CHUNK_W(CHUNK_W)) u_detect (
    .word_i     (word_in),
    .all_ones_o (hit)
  );

  flag_ctrl u_flags (
    .clk     (clk),
    .rst     (rst),
    .match_i (hit),
    .flags_o (flags)
  );

  assign armed_q   = flags.armed;
  assign held_q    = flags.held;
  assign trig_out  = armed_q | held_q;
  assign match_out = hit;
endmodule

// File: rtl/pulse_arm_trigger_chk.sv
module pulse_arm_trigger_chk #(
  parameter int unsigned WORD_W = 128
) (
  input logic              clk,
  input logic              rst,
  input logic [WORD_W-1:0] word_in,
  input logic              trig_out,
  input logic              match_out,
  input logic              armed_q,
  input logic              held_q
);
  logic primed = 1'b0;
  always_ff @(posedge clk) begin
    if (rst) primed <= 1'b1;
  end

  assert_all_ones_R1: assert property (@(posedge clk) disable iff (!primed)
    match_out == (word_in == {WORD_W{1'b1}}));

  assert_reset_arms_R2: assert property (@(posedge clk) disable iff (!primed)
    rst |=> (trig_out && armed_q && !held_q));

  assert_match_extends_R3: assert property (@(posedge clk) disable iff (!primed)
    (!rst && armed_q && match_out) |=> (trig_out && !armed_q && held_q));

  assert_flags_exclusive_R3: assert property (@(posedge clk) disable iff (!primed)
    !(armed_q && held_q));

  assert_no_match_ends_R4: assert property (@(posedge clk) disable iff (!primed)
    (!rst && armed_q && !match_out) |=> !trig_out);

  assert_single_extend_R5: assert property (@(posedge clk) disable iff (!primed)
    (!rst && held_q) |=> !trig_out);

  assert_stays_low_R6: assert property (@(posedge clk) disable iff (!primed)
    (!rst && !trig_out) |=> !trig_out);

  assert_rearm_only_reset_R6: assert property (@(posedge clk) disable iff (!primed)
    $rose(trig_out) |-> $past(rst));

  assert_reset_priority_R7: assert property (@(posedge clk) disable iff (!primed)
    (rst && held_q) |=> (armed_q && !held_q));
endmodule

bind pulse_arm_trigger pulse_arm_trigger_chk #(.WORD_W(WORD_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .word_in   (word_in),
  .trig_out  (trig_out),
  .match_out (match_out),
  .armed_q   (armed_q),
  .held_q    (held_q)
);

// File: tb/sim_pulse_arm_trigger.sv
`timescale 1ns/1ps
module sim_pulse_arm_trigger;
  localparam int W = 128;
  localparam logic [W-1:0] ONES = {W{1'b1}};

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] word_in = '0;
  logic         trig_out;
  logic         match_out;

  int  total = 0;
  int  bad   = 0;
  bit  done  = 1'b0;

  always #2 clk = ~clk;

  pulse_arm_trigger u0 (
    .clk       (clk),
    .rst       (rst),
    .word_in   (word_in),
    .trig_out  (trig_out),
    .match_out (match_out)
  );

  task automatic check(input logic act, input logic exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // advance one rising edge, land 1 ns after it
  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic hold_reset(input logic [W-1:0] w, input int n);
    rst = 1'b1;
    word_in = w;
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic t_reset_state();
    hold_reset('0, 3);
    check(trig_out, 1'b1, "R2 trigger high in reset");
    check(match_out, 1'b0, "R1 zero word no match");
  endtask

  task automatic t_release_no_match();
    hold_reset('0, 2);
    rst = 1'b0;
    word_in = '0;
    step();
    check(trig_out, 1'b0, "R4 no match at release ends pulse");
    word_in = ONES;
    #0.1;
    check(match_out, 1'b1, "R1 all ones match");
    for (int i = 0; i < 4; i++) begin
      step();
      check(trig_out, 1'b0, "R6 later match does not re-raise");
    end
  endtask

  task automatic t_release_match();
    hold_reset('0, 2);
    rst = 1'b0;
    word_in = ONES;
    step();
    check(trig_out, 1'b1, "R3 match at release extends");
    step();
    check(trig_out, 1'b0, "R5 extension not extended");
    step();
    check(trig_out, 1'b0, "R6 stays low after pulse");
  endtask

  task automatic t_match_during_reset();
    hold_reset(ONES, 2);
    check(trig_out, 1'b1, "R2 match during reset keeps armed");
    check(match_out, 1'b1, "R1 match during reset");
    rst = 1'b0;
    word_in = '0;
    step();
    check(trig_out, 1'b0, "R4 release without match");
  endtask

  task automatic t_reset_in_extension();
    hold_reset('0, 2);
    rst = 1'b0;
    word_in = ONES;
    step();
    check(trig_out, 1'b1, "R3 in extension");
    rst = 1'b1;
    step();
    check(trig_out, 1'b1, "R7 reset re-arms in extension");
    rst = 1'b0;
    word_in = ONES;
    step();
    check(trig_out, 1'b1, "R7 new release re-evaluates match");
    word_in = '0;
    step();
    check(trig_out, 1'b0, "R5 second pulse ends");
  endtask

  task automatic t_single_zero_bits();
    rst = 1'b0;
    foreach (int_pos[k]) begin
      word_in = ONES;
      word_in[int_pos[k]] = 1'b0;
      #0.1;
      check(match_out, 1'b0, "R1 single zero bit");
    end
    word_in = ONES;
    #0.1;
    check(match_out, 1'b1, "R1 all ones again");
    step();
    check(trig_out, 1'b0, "R6 no rise without reset");
  endtask

  int int_pos[5] = '{0, 15, 16, 64, 127};

  initial begin
    #1;
    t_reset_state();
    t_release_no_match();
    t_release_match();
    t_match_during_reset();
    t_reset_in_extension();
    t_single_zero_bits();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule